// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a parameterised number of external interrupt pins using the system clock. It turns each pin into an interrupt request under a two-bit sense mode that software programs. Every pin passes through a flop synchroniser. The synchronised sample is then compared with the sample from the previous clock, which gives edge and change detection. In the edge and change modes a detected event sets a sticky pending flag. The low-level mode has no flag: it passes the synchronised pin level straight through.

Each request goes to the CPU only when both gates are open: the global interrupt enable input and that pin's own mask bit. Software reaches the block through a plain register port with no stream traffic. Through it, software writes the sense modes and the masks, reads them back, and reads the pending flags. Writing a one to a flag bit clears that flag. A flag also clears when the CPU acknowledges that pin's interrupt.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense register reads 0 (every pin in low-level mode), the mask and pending registers read 0, and no request is raised.
- R2: Sense code 00 (bits [2i+1:2i] of address 0 for pin i) raises the request while the synchronised pin is low. The request follows the pin two clocks late and drops when the pin returns high. No pending flag is set in this mode.
- R3: Sense code 01 sets pin i's pending flag on every change of the sampled level, rising or falling. The flag is visible three clocks after the pin changes.
- R4: Sense code 10 sets the flag on falling edges only, and sense code 11 sets it on rising edges only. The opposite edge leaves the flag unchanged.
- R5: In the edge and change modes, a pulse held across a single rising clock edge is detected.
- R6: irq_req_o[i] is high only when gie_i is high, mask bit i (address 1, bit i) is set, and pin i has a pending flag or an active low level.
- R7: Writing address 2 with bit i set clears pin i's pending flag. A zero bit leaves its flag unchanged.
- R8: A high irq_ack_i[i] during a clock clears pin i's pending flag.
- R9: If an event and a clear (by write or by acknowledge) land on the same clock, the flag ends up set.
- R10: Address 0 reads back the sense codes, address 1 reads back the mask in the low bits with zeros above, address 2 reads the flags, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| irq_ack_i | input | NUM_PINS | Per-pin interrupt acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 sense, 1 mask, 2 flag clear |
| wr_data_i | input | 2*NUM_PINS | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 2*NUM_PINS | Read data, combinational from rd_addr_i |
| irq_req_o | output | NUM_PINS | Gated interrupt request per pin |

## Verification
The bench aims pulses of a single clock at the edge modes. A design that needed two samples of a level would miss them. It times a write-one-to-clear and an acknowledge to land on the same clock as a fresh event. A design that let the clear win would lose that interrupt. It checks that low-level mode sets no sticky flag and that its request drops as soon as the pin goes high; a latched level would keep requesting. Finally, random mode changes, mask changes and toggling of the global enable test that each pin decodes its own two-bit field and that a request never gets past a closed gate.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // The pins idle high, so every stage resets high.
  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign cur  = chain_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   cur,
  input  logic   prev,
  input  logic   clr,
  output logic   flag,
  output logic   pending
);
  logic ev;
  logic flag_q;

  always_comb begin
    unique case (mode)
      SNS_ANY:  ev = cur ^ prev;
      SNS_FALL: ev = prev & ~cur;
      SNS_RISE: ev = ~prev & cur;
      default:  ev = 1'b0;
    endcase
  end

  // An event on the same clock as a clear keeps the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= ev | (flag_q & ~clr);
  end

  assign flag    = flag_q;
  assign pending = (mode == SNS_LOW) ? ~cur : flag_q;

  p_level_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LOW && !flag_q) |=> !flag_q);
  p_fall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_FALL && prev && !cur) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> !flag_q);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev) |=> flag_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  localparam int unsigned DW = 2 * NUM_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NUM_PINS-1:0] flags,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     sense_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic [NUM_PINS-1:0] w1c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SENSE) sense_q <= wr_data;
      if (wr_addr == A_MASK)  mask_q  <= wr_data[NUM_PINS-1:0];
    end
  end

  assign w1c = (wr_en && wr_addr == A_FLAG) ? wr_data[NUM_PINS-1:0] : '0;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_SENSE: rd_data = sense_q;
      A_MASK:  rd_data[NUM_PINS-1:0] = mask_q;
      A_FLAG:  rd_data[NUM_PINS-1:0] = flags;
      default: rd_data = '0;
    endcase
  end

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DW = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                gie_i,
  input  logic [NUM_PINS-1:0] irq_ack_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [NUM_PINS-1:0] irq_req_o
);
  logic [DW-1:0]       sense_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] w1c;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] pending;

  ext_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .rd_addr (rd_addr_i),
    .flags   (flags),
    .rd_data (rd_data_o),
    .sense_q (sense_q),
    .mask_q  (mask_q),
    .w1c     (w1c)
  );

  generate
    genvar i;
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      logic cur;
      logic prev;

      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_i[i]),
        .cur   (cur),
        .prev  (prev)
      );

      ext_irq_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (sense_e'(sense_q[2*i +: 2])),
        .cur     (cur),
        .prev    (prev),
        .clr     (w1c[i] | irq_ack_i[i]),
        .flag    (flags[i]),
        .pending (pending[i])
      );
    end
  endgenerate

  assign irq_req_o = {NUM_PINS{gie_i}} & mask_q & pending;

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_req_o == '0));
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o & ~mask_q) == '0);
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb_top;
  localparam int NP = 2;
  localparam int DW = 2 * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '1;
  logic          gie_i = 1'b0;
  logic [NP-1:0] irq_ack_i = '0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [1:0]    rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [NP-1:0] irq_req_o;

  always #5 clk = ~clk;

  ext_irq_sense #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i),
    .irq_ack_i(irq_ack_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_req_o(irq_req_o)
  );

  // Reference model built from the requirements.
  logic [NP-1:0] m_s1, m_s2, m_prev, m_flag, m_mask;
  logic [DW-1:0] m_sense;
  int    n_vec = 0;
  int    n_bad = 0;
  int    n_cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic logic ev_of(logic [1:0] md, logic c, logic p);
    case (md)
      2'b01:   return c ^ p;
      2'b10:   return p & ~c;
      2'b11:   return ~p & c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NP-1:0] exp_irq();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      logic pend;
      pend = (m_sense[2*i +: 2] == 2'b00) ? ~m_s2[i] : m_flag[i];
      r[i] = gie_i & m_mask[i] & pend;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [1:0] a);
    logic [DW-1:0] r;
    r = '0;
    case (a)
      2'd0: r = m_sense;
      2'd1: r[NP-1:0] = m_mask;
      2'd2: r[NP-1:0] = m_flag;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1;
      m_flag = '0; m_mask = '0; m_sense = '0;
    end else begin
      logic [NP-1:0] nf;
      for (int i = 0; i < NP; i++) begin
        logic clr;
        clr = (wr_en_i && wr_addr_i == 2'd2 && wr_data_i[i]) || irq_ack_i[i];
        nf[i] = ev_of(m_sense[2*i +: 2], m_s2[i], m_prev[i]) | (m_flag[i] & ~clr);
      end
      m_flag = nf;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_i;
      if (wr_en_i && wr_addr_i == 2'd0) m_sense = wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd1) m_mask = wr_data_i[NP-1:0];
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (irq_req_o !== exp_irq()) begin
        n_bad++;
        $display("FAIL %s irq_req: actual %b expected %b", cur_req, irq_req_o, exp_irq());
      end
      n_vec++;
      if (rd_data_o !== exp_rd(rd_addr_i)) begin
        n_bad++;
        $display("FAIL %s rd_data@%0d: actual %h expected %h", cur_req, rd_addr_i,
                 rd_data_o, exp_rd(rd_addr_i));
      end
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    cyc(3);
    rst_n = 1'b1;
    // R1: reset values on every address
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      rd_addr_i = 2'(a);
      cyc();
    end
    // R10: readback of sense and mask
    cur_req = "R10";
    wr(2'd1, 4'b0011);
    rd_addr_i = 2'd1; cyc();
    wr(2'd0, 4'b1001);
    rd_addr_i = 2'd0; cyc();
    wr(2'd0, 4'b0000);
    rd_addr_i = 2'd2;
    gie_i = 1'b1;
    // R2: low level, unlatched, flag stays clear
    cur_req = "R2";
    pin_i[0] = 1'b0; cyc(5);
    pin_i[0] = 1'b1; cyc(4);
    // R3: any change
    cur_req = "R3";
    wr(2'd0, 4'b0101);
    cyc(2);
    pin_i[1] = 1'b0; cyc(4);
    wr(2'd2, 4'b0011); cyc();
    pin_i[1] = 1'b1; cyc(4);
    wr(2'd2, 4'b0011); cyc();
    // R4: falling only, then rising only
    cur_req = "R4";
    wr(2'd0, 4'b1110);
    pin_i = 2'b00; cyc(4);
    pin_i = 2'b11; cyc(4);
    wr(2'd2, 4'b0011); cyc(2);
    // R5: one-clock pulses
    cur_req = "R5";
    pin_i[0] = 1'b0; cyc(); pin_i[0] = 1'b1; cyc(4);
    // R6: gating by global enable and mask
    cur_req = "R6";
    gie_i = 1'b0; cyc(2);
    gie_i = 1'b1; wr(2'd1, 4'b0010); cyc(2);
    wr(2'd1, 4'b0011); cyc(2);
    // R7: zero bits leave flags, one bits clear
    cur_req = "R7";
    wr(2'd2, 4'b0010); cyc();
    wr(2'd2, 4'b0001); cyc();
    // R8: acknowledge clears
    cur_req = "R8";
    pin_i[1] = 1'b0; cyc(); pin_i[1] = 1'b1; cyc(4);
    irq_ack_i = 2'b10; cyc(); irq_ack_i = '0; cyc(2);
    // R9: event on the same clock as a write clear, then as an ack
    cur_req = "R9";
    wr(2'd0, 4'b0101);
    pin_i[0] = 1'b0; cyc(2);
    wr(2'd2, 4'b0001); cyc(2);
    pin_i[0] = 1'b1; cyc(2);
    irq_ack_i = 2'b01; cyc(); irq_ack_i = '0; cyc(2);
    // Random mix covering R2 R3 R4 R6 R7 R8 R9 R10
    cur_req = "random R3 R4 R6 R9";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 2) == 0) pin_i = NP'($urandom);
      irq_ack_i = ($urandom_range(0, 7) == 0) ? NP'($urandom) : '0;
      if ($urandom_range(0, 15) == 0) gie_i = ~gie_i;
      wr_en_i = ($urandom_range(0, 5) == 0);
      wr_addr_i = 2'($urandom);
      wr_data_i = DW'($urandom);
      rd_addr_i = 2'($urandom);
      cyc();
    end
    wr_en_i = 1'b0; irq_ack_i = '0;
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule